// File: doc/BRIEF.md
# Posted Write Burst Combiner (host to PCI)

This block sits between the host side of a bridge and a 32-bit multiplexed address/data bus of the PCI kind. The host side hands it single-dword write cycles through a valid/ready handshake. Each write carries a dword address, 32 data bits and four byte enables. Up to four such writes are held with their addresses. On the bus side the held writes are replayed as memory-write transactions, and a run of address-consecutive full-dword writes goes out as one burst with no wait states.

Every entry that arrives in time and continues the previous entry's address joins the running transaction. Any other entry closes the burst and opens a new address phase. When the bench or system connects the target-ready input, each data phase completes only when the target signals ready. When that input is configured out, the burst advances one dword per clock. A registered output gives one parity bit per 16-bit lane of the address/data bus, one clock after the values it covers, so that bus parity can be formed. The host side and the bus side share one clock in this slice.

Top module: `wpost_burst`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `post_ready` is 1, and `bus_frame`, `bus_irdy`, `bus_ad` and `lane_par` are all 0.
- R2: A write is accepted on a clock edge where `post_valid` and `post_ready` are both 1. `post_ready` is 0 exactly while four writes are held. It returns to 1 in the cycle after a data phase completes.
- R3: Every accepted write appears as exactly one completed data phase, in acceptance order. In that phase `bus_ad` carries its data and `bus_cbe_n` carries its byte enables inverted (bit i low means byte i written).
- R4: An address phase is a cycle with `bus_frame`=1 and `bus_irdy`=0. In it, `bus_ad` = {dword address, 2'b00} of the first write of the transaction and `bus_cbe_n` = 4'b0111 (memory write). The next cycle is always a data phase.
- R5: A write continues the current burst only if its dword address is the previous write's plus one and its byte enables are 4'b1111. Otherwise the previous write's data phase is the last one, and the write starts a new address phase.
- R6: `bus_irdy` is 1 in every data phase. `bus_frame` is 1 in every data phase except the last one of a transaction, where it is 0.
- R7: With target-ready held at 1, the n data phases of a transaction complete in the n consecutive cycles right after its address phase.
- R8: With target-ready used, a data phase completes only in a cycle where `bus_trdy` is 1. While it is 0, `bus_ad`, `bus_cbe_n`, `bus_frame` and `bus_irdy` hold their values.
- R9: When the block is built with `USE_TRDY`=0, `bus_trdy` is ignored. The bus outputs then match those of a target-ready build whose `bus_trdy` is held at 1.
- R10: `lane_par[k]` equals the XOR of `bus_ad[16k+15:16k]` as driven in the previous cycle.
- R11: After the last data phase of a transaction, at least one cycle with `bus_frame`=0 and `bus_irdy`=0 comes before the next address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| post_valid | input | 1 | Host offers a write |
| post_addr | input | 30 | Dword address of the offered write |
| post_data | input | 32 | Write data |
| post_be | input | 4 | Byte enables, active high |
| post_ready | output | 1 | A write can be accepted this cycle |
| bus_ad | output | 32 | Multiplexed address/data bus |
| bus_cbe_n | output | 4 | Command in the address phase, inverted byte enables in data phases |
| bus_frame | output | 1 | Transaction active; low in the last data phase |
| bus_irdy | output | 1 | Initiator ready, high in data phases |
| bus_trdy | input | 1 | Target ready; paces data phases when used |
| lane_par | output | 2 | Per-lane parity of the previous cycle's bus_ad |

## Verification
A wrong occupancy count shows on `post_ready` in the very cycle it goes wrong: the count either stalls the host with room left or admits a fifth write. A corrupt read pointer lets a data phase carry another entry's data or byte enables. A faulty chaining decision shows as a misplaced `bus_frame` fall or an extra or missing address phase, at most one cycle after the affected entry reaches the head. A stall or parity register fault shows on the next clock. The bench therefore compares every completed data phase, every address phase and every parity bit against values computed from the posted stream.

// File: rtl/wpost_pkg.sv
package wpost_pkg;
  localparam int ADDR_W = 30;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int OFS_W  = DATA_W - ADDR_W;

  localparam logic [BE_W-1:0] CMD_MEM_WR = 4'b0111;
  localparam logic [BE_W-1:0] CBE_IDLE   = '1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } post_entry_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_t;
endpackage

// File: rtl/wpost_fifo.sv
module wpost_fifo
  import wpost_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  post_entry_t             push_entry,
  input  logic                    pop,
  output logic [CNT_W-1:0]        count,
  output post_entry_t [DEPTH-1:0] peek
);
  post_entry_t      mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    if (pop)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
    if (push) wr_ptr_d = wr_ptr_q + PTR_W'(1);
    count_d = count_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_entry;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_peek
    logic [PTR_W-1:0] idx;
    assign idx     = rd_ptr_q + PTR_W'(k);
    assign peek[k] = mem[idx];
  end

  assign count = count_q;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(count_q) < DEPTH));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));
endmodule

// File: rtl/wpost_seq.sv
module wpost_seq
  import wpost_pkg::*;
#(
  parameter  int DEPTH    = 4,
  parameter  bit USE_TRDY = 1'b1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int AHEAD    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        count,
  input  post_entry_t [DEPTH-1:0] peek,
  input  logic                    bus_trdy,
  output logic                    pop,
  output logic [DATA_W-1:0]       bus_ad,
  output logic [BE_W-1:0]         bus_cbe_n,
  output logic                    bus_frame,
  output logic                    bus_irdy
);
  seq_state_t        st_q, st_d;
  logic [DATA_W-1:0] ad_q, ad_d;
  logic [BE_W-1:0]   cbe_q, cbe_d;
  logic              frame_q, frame_d;
  logic              irdy_q, irdy_d;
  logic              trdy_eff;
  logic              beat_done;

  if (USE_TRDY) begin : g_paced
    assign trdy_eff = bus_trdy;
  end else begin : g_free
    assign trdy_eff = 1'b1;
  end

  assign beat_done = irdy_q && trdy_eff;

  function automatic logic chains(post_entry_t prv, post_entry_t nxt);
    return (nxt.addr == prv.addr + ADDR_W'(1)) && (&nxt.be);
  endfunction

  always_comb begin
    st_d    = st_q;
    ad_d    = ad_q;
    cbe_d   = cbe_q;
    frame_d = frame_q;
    irdy_d  = irdy_q;
    pop     = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (count != '0) begin
          st_d    = SEQ_ADDR;
          ad_d    = {peek[0].addr, {OFS_W{1'b0}}};
          cbe_d   = CMD_MEM_WR;
          frame_d = 1'b1;
          irdy_d  = 1'b0;
        end
      end
      SEQ_ADDR: begin
        st_d    = SEQ_DATA;
        ad_d    = peek[0].data;
        cbe_d   = ~peek[0].be;
        irdy_d  = 1'b1;
        frame_d = (count > CNT_W'(1)) && chains(peek[0], peek[1]);
      end
      SEQ_DATA: begin
        if (beat_done) begin
          pop = 1'b1;
          if (frame_q) begin
            ad_d    = peek[1].data;
            cbe_d   = ~peek[1].be;
            frame_d = (count > CNT_W'(AHEAD)) && chains(peek[1], peek[AHEAD]);
          end else begin
            st_d    = SEQ_IDLE;
            ad_d    = '0;
            cbe_d   = CBE_IDLE;
            frame_d = 1'b0;
            irdy_d  = 1'b0;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      ad_q    <= '0;
      cbe_q   <= CBE_IDLE;
      frame_q <= 1'b0;
      irdy_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ad_q    <= ad_d;
      cbe_q   <= cbe_d;
      frame_q <= frame_d;
      irdy_q  <= irdy_d;
    end
  end

  assign bus_ad    = ad_q;
  assign bus_cbe_n = cbe_q;
  assign bus_frame = frame_q;
  assign bus_irdy  = irdy_q;

  assert_addr_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_frame && !bus_irdy) |=> bus_irdy);
  assert_hold_on_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && !trdy_eff) |=> ($stable(bus_ad) && $stable(bus_cbe_n) &&
                                 $stable(bus_frame) && bus_irdy));
  assert_idle_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && !bus_frame && trdy_eff) |=> (!bus_frame && !bus_irdy));
endmodule

// File: rtl/wpost_par.sv
module wpost_par #(
  parameter  int DATA_W = 32,
  parameter  int LANE_W = 16,
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad,
  output logic [LANES-1:0]  lane_par
);
  logic [LANES-1:0] par_q, par_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb par_d[g] = ^ad[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else        par_q <= par_d;
  end

  assign lane_par = par_q;
endmodule

// File: rtl/wpost_burst.sv
module wpost_burst
  import wpost_pkg::*;
#(
  parameter  int DEPTH    = 4,
  parameter  bit USE_TRDY = 1'b1,
  parameter  int LANE_W   = 16,
  localparam int LANES    = DATA_W / LANE_W,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic [ADDR_W-1:0] post_addr,
  input  logic [DATA_W-1:0] post_data,
  input  logic [BE_W-1:0]   post_be,
  output logic              post_ready,
  output logic [DATA_W-1:0] bus_ad,
  output logic [BE_W-1:0]   bus_cbe_n,
  output logic              bus_frame,
  output logic              bus_irdy,
  input  logic              bus_trdy,
  output logic [LANES-1:0]  lane_par
);
  logic                    push;
  logic                    pop;
  post_entry_t             in_entry;
  post_entry_t [DEPTH-1:0] peek;
  logic [CNT_W-1:0]        count;

  assign post_ready = (int'(count) < DEPTH);
  assign push       = post_valid && post_ready;
  assign in_entry   = '{addr: post_addr, data: post_data, be: post_be};

  wpost_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_entry (in_entry),
    .pop        (pop),
    .count      (count),
    .peek       (peek)
  );

  wpost_seq #(.DEPTH(DEPTH), .USE_TRDY(USE_TRDY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .peek      (peek),
    .bus_trdy  (bus_trdy),
    .pop       (pop),
    .bus_ad    (bus_ad),
    .bus_cbe_n (bus_cbe_n),
    .bus_frame (bus_frame),
    .bus_irdy  (bus_irdy)
  );

  wpost_par #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .ad       (bus_ad),
    .lane_par (lane_par)
  );

  assert_pop_needs_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> bus_irdy);
endmodule

// File: tb/wpost_burst_tb_top.sv
`timescale 1ns/1ps
module wpost_burst_tb_top;
  logic        clk;
  logic        rst_n;
  logic        post_valid;
  logic [29:0] post_addr;
  logic [31:0] post_data;
  logic [3:0]  post_be;
  logic        post_ready;
  logic [31:0] bus_ad;
  logic [3:0]  bus_cbe_n;
  logic        bus_frame, bus_irdy, bus_trdy;
  logic [1:0]  lane_par;

  logic        nt_valid, nt_ready;
  logic [31:0] nt_ad;
  logic [3:0]  nt_cbe_n;
  logic        nt_frame, nt_irdy;
  logic [1:0]  nt_par;

  logic        stall_all, rand_mode, cmp_nt, zero_wait;
  logic [15:0] lfsr;

  int n_checks, n_err, cyc, wd;
  logic [29:0] exp_addr [0:7];
  logic [31:0] exp_data [0:7];
  logic [3:0]  exp_be   [0:7];
  int exp_n, rd, bursts, bstart, pos;
  logic [29:0] cur_addr;
  logic        have_prev, prev_irdy, prev_trdy, prev_frame;
  logic [31:0] prev_ad;
  logic [3:0]  prev_cbe;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign bus_trdy = stall_all ? 1'b0 : (rand_mode ? lfsr[0] : 1'b1);
  assign nt_valid = post_valid && cmp_nt;

  always @(posedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  wpost_burst #(.DEPTH(4), .USE_TRDY(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_addr(post_addr),
    .post_data(post_data), .post_be(post_be), .post_ready(post_ready),
    .bus_ad(bus_ad), .bus_cbe_n(bus_cbe_n), .bus_frame(bus_frame),
    .bus_irdy(bus_irdy), .bus_trdy(bus_trdy), .lane_par(lane_par));

  wpost_burst #(.DEPTH(4), .USE_TRDY(1'b0)) dut_nt_i (
    .clk(clk), .rst_n(rst_n), .post_valid(nt_valid), .post_addr(post_addr),
    .post_data(post_data), .post_be(post_be), .post_ready(nt_ready),
    .bus_ad(nt_ad), .bus_cbe_n(nt_cbe_n), .bus_frame(nt_frame),
    .bus_irdy(nt_irdy), .bus_trdy(1'b0), .lane_par(nt_par));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      have_prev = 1'b0;
    end else begin
      cyc++;
      if (have_prev)
        chk(lane_par == {^prev_ad[31:16], ^prev_ad[15:0]}, "R10 lane parity",
            {30'd0, lane_par}, {30'd0, ^prev_ad[31:16], ^prev_ad[15:0]});
      if (have_prev && prev_irdy && !prev_trdy)
        chk(bus_ad == prev_ad && bus_cbe_n == prev_cbe && bus_frame == prev_frame && bus_irdy,
            "R8 hold during wait", bus_ad, prev_ad);
      if (bus_frame && !bus_irdy) begin
        chk(!(have_prev && prev_irdy), "R11 idle before address phase", {31'd0, prev_irdy}, 32'd0);
        chk(bus_cbe_n == 4'b0111, "R4 command", {28'd0, bus_cbe_n}, 32'h7);
        if (rd < exp_n)
          chk(bus_ad == {exp_addr[rd], 2'b00}, "R4 address", bus_ad, {exp_addr[rd], 2'b00});
        bstart = cyc;
        pos = 0;
        cur_addr = bus_ad[31:2];
        bursts++;
      end
      if (bus_irdy && bus_trdy) begin
        if (rd >= exp_n) begin
          chk(1'b0, "R3 unexpected data phase", bus_ad, 32'd0);
        end else begin
          bit last;
          last = (rd + 1 >= exp_n) ||
                 !((exp_addr[rd+1] == exp_addr[rd] + 30'd1) && (exp_be[rd+1] == 4'hF));
          chk(bus_ad == exp_data[rd], "R3 data", bus_ad, exp_data[rd]);
          chk(bus_cbe_n == ~exp_be[rd], "R3 byte enables", {28'd0, bus_cbe_n}, {28'd0, ~exp_be[rd]});
          chk(cur_addr == exp_addr[rd], "R5 burst address", {2'd0, cur_addr}, {2'd0, exp_addr[rd]});
          chk(bus_frame == !last, "R6 R5 frame in data phase", {31'd0, bus_frame}, {31'd0, !last});
          if (zero_wait)
            chk(cyc - bstart == pos + 1, "R7 zero wait", cyc - bstart, pos + 1);
          rd++;
          pos++;
          cur_addr = cur_addr + 30'd1;
        end
      end
      if (cmp_nt)
        chk(nt_ad == bus_ad && nt_cbe_n == bus_cbe_n && nt_frame == bus_frame &&
            nt_irdy == bus_irdy && nt_par == lane_par && nt_ready == post_ready,
            "R9 trdy ignored", nt_ad, bus_ad);
      have_prev  = 1'b1;
      prev_ad    = bus_ad;
      prev_cbe   = bus_cbe_n;
      prev_frame = bus_frame;
      prev_irdy  = bus_irdy;
      prev_trdy  = bus_trdy;
    end
  end

  task automatic post(input int k);
    post_addr  = exp_addr[k];
    post_data  = exp_data[k];
    post_be    = exp_be[k];
    post_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (post_ready) break;
    end
    @(posedge clk);
    #1;
    post_valid = 1'b0;
  endtask

  task automatic build(input int m);
    for (int i = 0; i < 6; i++) begin
      if (i == 0) begin
        exp_addr[i] = 30'h100 * 30'(m) + 30'(m);
        exp_be[i]   = 4'hF;
      end else if (m[i-1]) begin
        if (i % 2 == 1) begin
          exp_addr[i] = exp_addr[i-1] + 30'd3;
          exp_be[i]   = 4'hF;
        end else begin
          exp_addr[i] = exp_addr[i-1] + 30'd1;
          exp_be[i]   = 4'b0011;
        end
      end else begin
        exp_addr[i] = exp_addr[i-1] + 30'd1;
        exp_be[i]   = 4'hF;
      end
      exp_data[i] = {8'h5A, 8'(m), 8'(i), 8'(m ^ i)};
    end
    exp_n  = 6;
    rd     = 0;
    bursts = 0;
  endtask

  task automatic drain_and_count(input int expb, input string tag);
    while (rd != exp_n) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(bursts == expb, tag, bursts, expb);
  endtask

  initial begin
    n_checks = 0; n_err = 0; cyc = 0; wd = 0;
    exp_n = 0; rd = 0; bursts = 0; bstart = 0; pos = 0;
    have_prev = 1'b0;
    rst_n = 1'b0; post_valid = 1'b0; post_addr = '0; post_data = '0; post_be = '0;
    stall_all = 1'b0; rand_mode = 1'b0; cmp_nt = 1'b1; zero_wait = 1'b1;
    repeat (3) @(negedge clk);
    chk(post_ready && !bus_frame && !bus_irdy && bus_ad == 0 && lane_par == 0,
        "R1 reset state", bus_ad, 32'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(post_ready && !bus_frame && !bus_irdy && bus_ad == 0 && lane_par == 0,
        "R1 after release", {31'd0, post_ready}, 32'd1);
    @(posedge clk);
    #1;

    // Zero-wait sweep over every break pattern (R5 R7 R9)
    for (int m = 0; m < 32; m++) begin
      build(m);
      for (int k = 0; k < 6; k++) post(k);
      drain_and_count(1 + $countones(m[4:0]), "R5 burst count zero-wait");
      @(posedge clk);
      #1;
    end

    // Target-paced sweep with pseudo-random ready (R8)
    cmp_nt = 1'b0;
    zero_wait = 1'b0;
    rand_mode = 1'b1;
    for (int m = 0; m < 32; m++) begin
      build(m);
      for (int k = 0; k < 6; k++) post(k);
      drain_and_count(1 + $countones(m[4:0]), "R5 burst count paced");
      @(posedge clk);
      #1;
    end

    // Full buffer (R2)
    rand_mode = 1'b0;
    stall_all = 1'b1;
    build(7);
    exp_addr[0] = 30'h2000;
    for (int i = 1; i < 4; i++) begin
      exp_addr[i] = exp_addr[i-1] + 30'd1;
      exp_be[i]   = 4'hF;
    end
    exp_addr[4] = 30'h3000;
    exp_be[4]   = 4'hF;
    exp_n = 5;
    for (int k = 0; k < 4; k++) post(k);
    @(negedge clk);
    chk(!post_ready, "R2 ready low when full", {31'd0, post_ready}, 32'd0);
    repeat (4) @(negedge clk);
    chk(!post_ready && rd == 0, "R8 R2 no transfer while target waits", rd, 0);
    @(posedge clk);
    #1 stall_all = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(post_ready, "R2 ready after one data phase", {31'd0, post_ready}, 32'd1);
    @(posedge clk);
    #1;
    post(4);
    drain_and_count(2, "R5 burst count after full");

    finish_run();
  end
endmodule